// File: doc/BRIEF.md
# Region-Based I/O Wait-State Generator

This block sequences reads and writes into a separate 2048-word, 16-bit external I/O space on a DSP-style external bus. The core hands it an access request carrying an 11-bit I/O address, a direction and write data. The block stretches that access by a programmable number of wait cycles, then acknowledges it to the core. The wait count is not one global value. It is looked up per access from four independently programmed 3-bit fields. The top two address bits pick which field applies, which splits the space into four 512-word regions that can each be paced to suit the device behind it.

All of the wait fields live in a single control word. The core writes that word through a register-write port at data-memory address 0x3FFE, and the word's current value is always visible on a read-back output. While an access runs, the block drives the I/O select, one data strobe, the 14-bit external address and, for writes, the write data. It captures read data on the final cycle of the access.

Top module: `io_region_wait_gen`

## Requirements
- R1: After reset, `cfg_rdata` reads 0x7FFF, so every wait field is 7. `io_sel`, `rd_strobe`, `wr_strobe` and `ack` are all low.
- R2: A `cfg_wr_en` pulse with `cfg_addr` equal to 0x3FFE loads the control word, and the new value is visible on `cfg_rdata` the following cycle. The field layout is: region 0 wait in bits [2:0], region 1 in [5:3], region 2 in [8:6], region 3 in [11:9], and a data-memory wait field in [14:12]. A write to any other address leaves the word unchanged.
- R3: Bit 15 of the control word is reserved. A write to it is ignored, and it always reads 0.
- R4: An access to I/O address A uses the wait field N selected by A[10:9]: values 0 and 1 pick regions 0 and 1, 2 picks region 2, 3 picks region 3. The access lasts N+1 cycles, and `io_sel` is high for exactly those cycles.
- R5: `ack` is high for exactly one cycle, the final cycle of the access, and never while `io_sel` is low.
- R6: During an access, `ext_addr` equals the request address zero-extended to 14 bits, so bits [13:11] are 0. It is held constant for the whole access.
- R7: A write access (`req_write`=1) holds `wr_strobe` high and `rd_strobe` low for the whole access, and `ext_wdata` carries the request data throughout.
- R8: A read access (`req_write`=0) holds `rd_strobe` high and `wr_strobe` low for the whole access. `rd_data` takes the `ext_rdata` value present in the final cycle and keeps it until the next read completes. Write accesses leave `rd_data` unchanged.
- R9: The wait count is latched when an access starts. A control-word write during an access changes neither the length of that access nor its strobes.
- R10: A request is accepted only while idle. A request held high through an access's final cycle starts the next access only after at least one cycle with `io_sel` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Core register-write strobe |
| cfg_addr | input | 14 | Core register-write address |
| cfg_wdata | input | 16 | Core register-write data |
| cfg_rdata | output | 16 | Current wait control word |
| req_valid | input | 1 | I/O access request, held until `ack` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 11 | I/O space word address |
| req_wdata | input | 16 | Write data |
| ack | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Captured read data |
| ext_addr | output | 14 | External address bus |
| ext_wdata | output | 16 | External write data |
| ext_rdata | input | 16 | External read data |
| io_sel | output | 1 | I/O space select, high for the whole access |
| rd_strobe | output | 1 | Read strobe |
| wr_strobe | output | 1 | Write strobe |

## Verification
The bench builds the block with its default parameters: four regions, 3-bit wait fields, an 11-bit I/O address and a 14-bit external address. With these values every wait count from 0 to 7 and every region can be reached within a few hundred cycles of random accesses. That includes the longest access of eight cycles, the zero-wait single-cycle access, and a control-word write that lands in the middle of an access. Because the default data width exactly fills the four region fields, the data-memory field and the reserved bit, the reserved-bit masking and the field boundaries are exercised directly.

// File: rtl/io_region_wait_pkg.sv
package io_region_wait_pkg;

    // Default geometry of the I/O space and of the wait control word.
    localparam int IO_ADDR_W   = 11;
    localparam int EXT_ADDR_W  = 14;
    localparam int DATA_W      = 16;
    localparam int REGION_N    = 4;
    localparam int WAIT_W      = 3;
    localparam logic [EXT_ADDR_W-1:0] CFG_WORD_ADDR = 14'h3FFE;

    // Sequencer state.
    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_BUSY = 1'b1
    } seq_state_e;

    // Lowest bit position of a wait field inside the packed field vector.
    function automatic int field_lsb(input int idx, input int ww);
        return idx * ww;
    endfunction

endpackage

// File: rtl/io_wait_cfg_reg.sv
module io_wait_cfg_reg
    import io_region_wait_pkg::*;
#(
    parameter int EXT_AW   = EXT_ADDR_W,
    parameter int DW       = DATA_W,
    parameter int NREG     = REGION_N,
    parameter int WW       = WAIT_W,
    parameter logic [EXT_AW-1:0] CFG_ADDR = CFG_WORD_ADDR
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_wr_en,
    input  logic [EXT_AW-1:0]    cfg_addr,
    input  logic [DW-1:0]        cfg_wdata,
    output logic [NREG*WW-1:0]   region_waits,
    output logic [DW-1:0]        cfg_word
);
    localparam int REGION_BITS = NREG * WW;
    localparam int DM_LSB      = REGION_BITS;
    localparam int RSVD_LSB    = REGION_BITS + WW;

    logic          hit;
    logic [WW-1:0] dm_wait_q;
    logic          unused_rsvd_bits;

    assign hit = cfg_wr_en && (cfg_addr == CFG_ADDR);

    // One register per region field.
    for (genvar g = 0; g < NREG; g++) begin : g_field
        logic [WW-1:0] field_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                field_q <= '1;
            end else if (hit) begin
                field_q <= cfg_wdata[field_lsb(g, WW) +: WW];
            end
        end
        assign region_waits[field_lsb(g, WW) +: WW] = field_q;
    end

    // Data-memory wait field: stored and read back only.
    always_ff @(posedge clk) begin
        if (rst) begin
            dm_wait_q <= '1;
        end else if (hit) begin
            dm_wait_q <= cfg_wdata[DM_LSB +: WW];
        end
    end

    // Reserved bits carry no storage.
    assign unused_rsvd_bits = ^cfg_wdata[DW-1:RSVD_LSB];

    always_comb begin
        cfg_word                  = '0;
        cfg_word[RSVD_LSB-1:0]    = {dm_wait_q, region_waits};
    end

endmodule

// File: rtl/io_region_sel.sv
module io_region_sel
    import io_region_wait_pkg::*;
#(
    parameter int NREG = REGION_N,
    parameter int WW   = WAIT_W,
    localparam int SEL_W = $clog2(NREG)
) (
    input  logic [NREG*WW-1:0] region_waits,
    input  logic [SEL_W-1:0]   region_idx,
    output logic [WW-1:0]      wait_cnt
);
    always_comb begin
        wait_cnt = '0;
        for (int i = 0; i < NREG; i++) begin
            if (region_idx == SEL_W'(i)) begin
                wait_cnt = region_waits[field_lsb(i, WW) +: WW];
            end
        end
    end

endmodule

// File: rtl/io_access_seq.sv
module io_access_seq
    import io_region_wait_pkg::*;
#(
    parameter int IO_AW  = IO_ADDR_W,
    parameter int EXT_AW = EXT_ADDR_W,
    parameter int DW     = DATA_W,
    parameter int WW     = WAIT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [IO_AW-1:0]  req_addr,
    input  logic [DW-1:0]     req_wdata,
    input  logic [WW-1:0]     wait_cnt,
    input  logic [DW-1:0]     ext_rdata,
    output logic [EXT_AW-1:0] ext_addr,
    output logic [DW-1:0]     ext_wdata,
    output logic              io_sel,
    output logic              rd_strobe,
    output logic              wr_strobe,
    output logic              ack,
    output logic [DW-1:0]     rd_data
);
    localparam int PAD_W = EXT_AW - IO_AW;

    typedef struct packed {
        logic             wr;
        logic [IO_AW-1:0] addr;
        logic [DW-1:0]    wdata;
    } acc_ctx_t;

    seq_state_e    state_q;
    logic [WW-1:0] cnt_q;
    acc_ctx_t      ctx_q;
    logic [DW-1:0] rd_data_q;
    logic          busy;
    logic          last_cycle;

    assign busy       = (state_q == SEQ_BUSY);
    assign last_cycle = busy && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= SEQ_IDLE;
            cnt_q     <= '0;
            ctx_q     <= '0;
            rd_data_q <= '0;
        end else begin
            unique case (state_q)
                SEQ_IDLE: begin
                    if (req_valid) begin
                        state_q     <= SEQ_BUSY;
                        cnt_q       <= wait_cnt;
                        ctx_q.wr    <= req_write;
                        ctx_q.addr  <= req_addr;
                        ctx_q.wdata <= req_wdata;
                    end
                end
                SEQ_BUSY: begin
                    if (cnt_q == '0) begin
                        state_q <= SEQ_IDLE;
                        if (!ctx_q.wr) begin
                            rd_data_q <= ext_rdata;
                        end
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    always_comb begin
        io_sel    = busy;
        rd_strobe = busy && !ctx_q.wr;
        wr_strobe = busy && ctx_q.wr;
        ack       = last_cycle;
        ext_addr  = busy ? {{PAD_W{1'b0}}, ctx_q.addr} : '0;
        ext_wdata = (busy && ctx_q.wr) ? ctx_q.wdata : '0;
        rd_data   = rd_data_q;
    end

endmodule

// File: rtl/io_region_wait_gen.sv
module io_region_wait_gen
    import io_region_wait_pkg::*;
#(
    parameter int IO_AW  = IO_ADDR_W,
    parameter int EXT_AW = EXT_ADDR_W,
    parameter int DW     = DATA_W,
    parameter int NREG   = REGION_N,
    parameter int WW     = WAIT_W,
    parameter logic [EXT_AW-1:0] CFG_ADDR = CFG_WORD_ADDR
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr_en,
    input  logic [EXT_AW-1:0] cfg_addr,
    input  logic [DW-1:0]     cfg_wdata,
    output logic [DW-1:0]     cfg_rdata,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [IO_AW-1:0]  req_addr,
    input  logic [DW-1:0]     req_wdata,
    output logic              ack,
    output logic [DW-1:0]     rd_data,
    output logic [EXT_AW-1:0] ext_addr,
    output logic [DW-1:0]     ext_wdata,
    input  logic [DW-1:0]     ext_rdata,
    output logic              io_sel,
    output logic              rd_strobe,
    output logic              wr_strobe
);
    localparam int SEL_W = $clog2(NREG);

    logic [NREG*WW-1:0] region_waits;
    logic [WW-1:0]      sel_wait;
    logic [SEL_W-1:0]   region_idx;

    assign region_idx = req_addr[IO_AW-1 -: SEL_W];

    io_wait_cfg_reg #(
        .EXT_AW   (EXT_AW),
        .DW       (DW),
        .NREG     (NREG),
        .WW       (WW),
        .CFG_ADDR (CFG_ADDR)
    ) u_cfg (
        .clk          (clk),
        .rst          (rst),
        .cfg_wr_en    (cfg_wr_en),
        .cfg_addr     (cfg_addr),
        .cfg_wdata    (cfg_wdata),
        .region_waits (region_waits),
        .cfg_word     (cfg_rdata)
    );

    io_region_sel #(
        .NREG (NREG),
        .WW   (WW)
    ) u_sel (
        .region_waits (region_waits),
        .region_idx   (region_idx),
        .wait_cnt     (sel_wait)
    );

    io_access_seq #(
        .IO_AW  (IO_AW),
        .EXT_AW (EXT_AW),
        .DW     (DW),
        .WW     (WW)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .wait_cnt  (sel_wait),
        .ext_rdata (ext_rdata),
        .ext_addr  (ext_addr),
        .ext_wdata (ext_wdata),
        .io_sel    (io_sel),
        .rd_strobe (rd_strobe),
        .wr_strobe (wr_strobe),
        .ack       (ack),
        .rd_data   (rd_data)
    );

endmodule

// File: rtl/io_region_wait_chk.sv
module io_region_wait_chk #(
    parameter int EXT_AW = 14,
    parameter int DW     = 16,
    parameter int WW     = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              io_sel,
    input logic              rd_strobe,
    input logic              wr_strobe,
    input logic              ack,
    input logic [EXT_AW-1:0] ext_addr,
    input logic [DW-1:0]     ext_wdata
);
    localparam logic [WW:0] LEN_LIMIT = {1'b1, {WW{1'b0}}};

    logic [WW:0] len_q;

    always_ff @(posedge clk) begin
        if (rst || !io_sel) begin
            len_q <= '0;
        end else begin
            len_q <= len_q + 1'b1;
        end
    end

    AST_ACK_IN_ACCESS: assert property (@(posedge clk) disable iff (rst) ack |-> io_sel); // R5
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst) ack |=> !ack); // R5
    AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) !(rd_strobe && wr_strobe)); // R7
    AST_STROBE_FOLLOWS_SEL: assert property (@(posedge clk) disable iff (rst) io_sel == (rd_strobe || wr_strobe)); // R4
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst) (io_sel && !ack) |=> $stable(ext_addr)); // R6
    AST_WDATA_HELD: assert property (@(posedge clk) disable iff (rst) (wr_strobe && !ack) |=> ($stable(ext_wdata) && wr_strobe)); // R7
    AST_IDLE_GAP: assert property (@(posedge clk) disable iff (rst) ack |=> !io_sel); // R10
    AST_MAX_LENGTH: assert property (@(posedge clk) disable iff (rst) io_sel |-> (len_q < LEN_LIMIT)); // R4

endmodule

bind io_region_wait_gen io_region_wait_chk #(
    .EXT_AW (EXT_AW),
    .DW     (DW),
    .WW     (WW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .io_sel    (io_sel),
    .rd_strobe (rd_strobe),
    .wr_strobe (wr_strobe),
    .ack       (ack),
    .ext_addr  (ext_addr),
    .ext_wdata (ext_wdata)
);

// File: tb/io_region_wait_gen_tb_top.sv
module io_region_wait_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_wr_en;
    logic [13:0] cfg_addr;
    logic [15:0] cfg_wdata;
    logic [15:0] cfg_rdata;
    logic        req_valid;
    logic        req_write;
    logic [10:0] req_addr;
    logic [15:0] req_wdata;
    logic        ack;
    logic [15:0] rd_data;
    logic [13:0] ext_addr;
    logic [15:0] ext_wdata;
    logic [15:0] ext_rdata;
    logic        io_sel;
    logic        rd_strobe;
    logic        wr_strobe;

    int          checks = 0;
    int          errors = 0;
    bit          done = 0;
    logic [15:0] model_cfg;
    logic [15:0] model_rd;

    always #4 clk = ~clk;

    io_region_wait_gen dut_i (
        .clk(clk), .rst(rst),
        .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .ack(ack), .rd_data(rd_data),
        .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata),
        .io_sel(io_sel), .rd_strobe(rd_strobe), .wr_strobe(wr_strobe)
    );

    function automatic int exp_wait(input logic [15:0] word, input logic [10:0] a);
        return int'((word >> (3 * int'(a[10:9]))) & 16'h7);
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [13:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1;
        cfg_addr  = a;
        cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        if (a == 14'h3FFE) model_cfg = d & 16'h7FFF;
        check(cfg_rdata == model_cfg, "R2 control word", 32'(cfg_rdata), 32'(model_cfg));
        check(cfg_rdata[15] == 1'b0, "R3 reserved bit", 32'(cfg_rdata[15]), 32'd0);
    endtask

    task automatic do_access(input bit wr, input logic [10:0] a, input logic [15:0] wd, input bit mid_cfg);
        int          n;
        int          cycles;
        bit          seen_ack;
        bit          addr_ok;
        bit          strobe_ok;
        bit          wdata_ok;
        logic [15:0] last_rd;
        n         = exp_wait(model_cfg, a);
        cycles    = 0;
        seen_ack  = 0;
        addr_ok   = 1;
        strobe_ok = 1;
        wdata_ok  = 1;
        last_rd   = '0;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = wd;
        ext_rdata = 16'($urandom);
        while (!seen_ack && cycles < 20) begin
            @(negedge clk);
            if (cfg_wr_en) cfg_wr_en = 1'b0;
            if (io_sel) begin
                cycles++;
                if (ext_addr != {3'b000, a}) addr_ok = 0;
                if (rd_strobe != !wr || wr_strobe != wr) strobe_ok = 0;
                if (wr && ext_wdata != wd) wdata_ok = 0;
            end
            if (ack) begin
                seen_ack  = 1;
                last_rd   = ext_rdata;
                req_valid = 1'b0;
            end else begin
                ext_rdata = 16'($urandom);
                if (mid_cfg && cycles == 1) begin
                    cfg_wr_en = 1'b1;
                    cfg_addr  = 14'h3FFE;
                    cfg_wdata = model_cfg ^ (16'h7 << (3 * int'(a[10:9])));
                    model_cfg = cfg_wdata & 16'h7FFF;
                end
            end
        end
        req_valid = 1'b0;
        check(seen_ack, "R5 ack seen", 32'(seen_ack), 32'd1);
        check(cycles == n + 1, mid_cfg ? "R9 length latched" : "R4 access length", 32'(cycles), 32'(n + 1));
        check(addr_ok, "R6 external address", 32'(ext_addr), 32'(a));
        check(strobe_ok, wr ? "R7 write strobes" : "R8 read strobes", 32'(strobe_ok), 32'd1);
        if (wr) check(wdata_ok, "R7 write data", 32'(ext_wdata), 32'(wd));
        @(negedge clk);
        check(!io_sel && !ack, "R5 ack single cycle", {30'd0, io_sel, ack}, 32'd0);
        if (!wr) model_rd = last_rd;
        check(rd_data == model_rd, "R8 read data", 32'(rd_data), 32'(model_rd));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=0x0 expected=0x1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst       = 1'b1;
        cfg_wr_en = 1'b0;
        cfg_addr  = '0;
        cfg_wdata = '0;
        req_valid = 1'b0;
        req_write = 1'b0;
        req_addr  = '0;
        req_wdata = '0;
        ext_rdata = '0;
        model_cfg = 16'h7FFF;
        model_rd  = 16'h0000;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(cfg_rdata == 16'h7FFF, "R1 reset word", 32'(cfg_rdata), 32'h7FFF);
        check({io_sel, rd_strobe, wr_strobe, ack} == 4'b0, "R1 reset outputs",
              32'({io_sel, rd_strobe, wr_strobe, ack}), 32'd0);

        // R4 reset waits: longest access
        do_access(1'b0, 11'h123, 16'h0, 1'b0);

        // R3 reserved bit ignored; R2 foreign address ignored
        cfg_write(14'h3FFE, 16'hFFFF);
        cfg_write(14'h3FFD, 16'h0000);
        check(cfg_rdata == 16'h7FFF, "R2 other address ignored", 32'(cfg_rdata), 32'h7FFF);

        // R2 / R4 field placement: regions 0..3 = 0,3,5,7, dm = 2
        cfg_write(14'h3FFE, {1'b1, 3'd2, 3'd7, 3'd5, 3'd3, 3'd0});
        do_access(1'b1, 11'h000, 16'hA5A5, 1'b0);
        do_access(1'b0, 11'h1FF, 16'h0, 1'b0);
        do_access(1'b1, 11'h200, 16'h1234, 1'b0);
        do_access(1'b0, 11'h3FF, 16'h0, 1'b0);
        do_access(1'b1, 11'h400, 16'hFFFF, 1'b0);
        do_access(1'b0, 11'h5FF, 16'h0, 1'b0);
        do_access(1'b1, 11'h600, 16'h0001, 1'b0);
        do_access(1'b0, 11'h7FF, 16'h0, 1'b0);
        check(cfg_rdata[14:12] == 3'd2, "R2 data-memory field", 32'(cfg_rdata[14:12]), 32'd2);

        // R9 mid-access control write must not alter the running access
        do_access(1'b0, 11'h480, 16'h0, 1'b1);
        do_access(1'b1, 11'h6AA, 16'h5A5A, 1'b1);

        // R10 request held through ack: one idle cycle then a new access
        cfg_write(14'h3FFE, 16'h0001);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 11'h010; req_wdata = 16'hBEEF;
        @(negedge clk);
        check(io_sel && !ack, "R10 first cycle", {30'd0, io_sel, ack}, 32'd2);
        @(negedge clk);
        check(io_sel && ack, "R10 final cycle", {30'd0, io_sel, ack}, 32'd3);
        @(negedge clk);
        check(!io_sel, "R10 idle gap", 32'(io_sel), 32'd0);
        @(negedge clk);
        check(io_sel, "R10 held request accepted", 32'(io_sel), 32'd1);
        req_valid = 1'b0;
        @(negedge clk);
        check(ack, "R10 second access ack", 32'(ack), 32'd1);
        @(negedge clk);
        check(!io_sel, "R10 back to idle", 32'(io_sel), 32'd0);

        // Constrained random mix
        for (int i = 0; i < 80; i++) begin
            int sel = int'($urandom_range(0, 9));
            if (sel == 0) cfg_write(14'h3FFE, 16'($urandom));
            else if (sel == 1) cfg_write(14'($urandom), 16'($urandom));
            else do_access(1'($urandom), 11'($urandom), 16'($urandom), sel == 2);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule